// File: doc/BRIEF.md
# Rectangle Copy Blit Engine

This block is a register-programmed accelerator that moves a rectangular patch of a 1920 x 1080 frame buffer to another place in the same buffer. Pixels are 16-bit words in 5-6-5 RGB form. The engine does not interpret them. A host sets six coordinate registers: the patch width, the patch height, the source corner and the destination corner. Writing the destination row register launches the copy. While the copy runs, the host's ready signal is held low. This stalls the host until every pixel has been moved.

The engine reaches the frame buffer through a single-port memory interface. That memory returns read data one clock after a read request. Each pixel costs two cycles: a read of the source word, then a write of that word to the matching destination location. Source and destination can overlap. For that reason, the engine picks its scan direction at launch. It either starts at the top-left corner and moves forward in raster order, or starts at the bottom-right corner and moves backwards. In both cases, no source pixel is overwritten before it has been read.

Top module: `rect_blit`

## Requirements
- R1: After reset, host_ready_o is 1, mem_req_o is 0, and all six registers read back as 0.
- R2: The registers sit at these host_addr_i values: 0 width, 1 height, 2 source x, 3 source y, 4 destination x, 5 destination y. Each register stores the low 11 bits of a write. host_rdata_o returns the selected register zero-extended to 16 bits, and it is combinational on host_addr_i. Addresses 6 and 7 read as 0.
- R3: A write to address 5 while width and height are both nonzero starts a copy. host_ready_o is 0 from the next cycle until the copy ends.
- R4: A write to address 5 while width or height is 0 makes no memory access, and host_ready_o stays 1.
- R5: Each pixel takes one read cycle (mem_req_o=1, mem_we_o=0), followed at once by one write cycle (mem_req_o=1, mem_we_o=1). The write cycle carries the word that the memory returned, one clock after the read. A w x h copy keeps host_ready_o low for exactly 2*w*h cycles.
- R6: The memory address of a pixel at column x and row y is y*1920 + x, for both source and destination.
- R7: If the destination row is above the source row, or both are on the same row and the destination column is not to the right of the source column, the scan runs forward from the top-left pixel. It moves along each row, left to right, and then down to the next row.
- R8: In every other case, the scan runs backwards from the bottom-right pixel, right to left and bottom to top. In both directions, the destination ends up as an exact copy of the source contents taken before the launch, including when the two regions overlap.
- R9: Host writes made while a copy is running are ignored. The register values and the copy in progress are unaffected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| host_sel_i | input | 1 | Host access strobe |
| host_we_i | input | 1 | Host write enable, qualified by host_sel_i |
| host_addr_i | input | 3 | Register select |
| host_wdata_i | input | 16 | Host write data |
| host_rdata_o | output | 16 | Selected register, zero-extended |
| host_ready_o | output | 1 | Low while a copy runs (stalls the host) |
| mem_req_o | output | 1 | Frame-buffer access request |
| mem_we_o | output | 1 | Frame-buffer write enable |
| mem_addr_o | output | 21 | Frame-buffer word address |
| mem_wdata_o | output | 16 | Pixel word to write |
| mem_rdata_i | input | 16 | Pixel word read, valid one clock after the read request |

## Verification
The hardest situation to reach is an overlapping copy where the wrong scan direction corrupts the result. The worst case is a shift of one pixel along the same row, because there the order within a row matters as much as the order between rows. The stimulus places about half of the random destinations within three pixels of their source in both axes. It adds directed one-pixel shifts in all four directions. Each result is compared with a reference model that snapshots the source before writing. The address of the first write shows which scan direction was taken.

// File: rtl/blit_pkg.sv
package blit_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RD   = 2'd1,
    ST_WR   = 2'd2
  } scan_st_e;

  localparam int unsigned OFS_WIDTH  = 0;
  localparam int unsigned OFS_HEIGHT = 1;
  localparam int unsigned OFS_SRC_X  = 2;
  localparam int unsigned OFS_SRC_Y  = 3;
  localparam int unsigned OFS_DST_X  = 4;
  localparam int unsigned OFS_DST_Y  = 5;
  localparam int unsigned NUM_REGS   = 6;
endpackage

// File: rtl/blit_regs.sv
module blit_regs
  import blit_pkg::*;
#(
  parameter int unsigned COORD_W = 11,
  parameter int unsigned DATA_W  = 16,
  parameter int unsigned SEL_W   = 3
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               wr_en_i,
  input  logic [SEL_W-1:0]   sel_i,
  input  logic [DATA_W-1:0]  wdata_i,
  output logic [DATA_W-1:0]  rdata_o,
  output logic [COORD_W-1:0] width_o,
  output logic [COORD_W-1:0] height_o,
  output logic [COORD_W-1:0] src_x_o,
  output logic [COORD_W-1:0] src_y_o,
  output logic [COORD_W-1:0] dst_x_o,
  output logic [COORD_W-1:0] new_dst_y_o,
  output logic               launch_o
);
  logic [COORD_W-1:0] regs [NUM_REGS];
  logic               unused_hi;

  assign unused_hi = ^wdata_i[DATA_W-1:COORD_W];

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
    logic [COORD_W-1:0] q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) q <= '0;
      else if (wr_en_i && sel_i == SEL_W'(g)) q <= wdata_i[COORD_W-1:0];
    end
    assign regs[g] = q;
  end

  always_comb begin
    rdata_o = '0;
    for (int k = 0; k < NUM_REGS; k++) begin
      if (sel_i == SEL_W'(k)) rdata_o = {{(DATA_W-COORD_W){1'b0}}, regs[k]};
    end
  end

  assign width_o     = regs[OFS_WIDTH];
  assign height_o    = regs[OFS_HEIGHT];
  assign src_x_o     = regs[OFS_SRC_X];
  assign src_y_o     = regs[OFS_SRC_Y];
  assign dst_x_o     = regs[OFS_DST_X];
  // destination row as it will be after this write
  assign new_dst_y_o = wdata_i[COORD_W-1:0];
  assign launch_o    = wr_en_i && (sel_i == SEL_W'(OFS_DST_Y)) &&
                       (regs[OFS_WIDTH] != '0) && (regs[OFS_HEIGHT] != '0);

  // R9
  width_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_en_i |=> $stable(width_o))
    else $error("width changed without a write");

  // R2
  src_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_en_i |=> $stable(src_x_o) && $stable(src_y_o) && $stable(dst_x_o))
    else $error("coordinate changed without a write");
endmodule

// File: rtl/blit_scan.sv
module blit_scan
  import blit_pkg::*;
#(
  parameter int unsigned COORD_W = 11
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               start_i,
  input  logic [COORD_W-1:0] width_i,
  input  logic [COORD_W-1:0] height_i,
  input  logic [COORD_W-1:0] src_x_i,
  input  logic [COORD_W-1:0] src_y_i,
  input  logic [COORD_W-1:0] dst_x_i,
  input  logic [COORD_W-1:0] new_dst_y_i,
  output logic               busy_o,
  output logic               rd_o,
  output logic               wr_o,
  output logic [COORD_W-1:0] off_x_o,
  output logic [COORD_W-1:0] off_y_o
);
  scan_st_e           st_q;
  logic               rev_q;
  logic [COORD_W-1:0] ox_q, oy_q;
  logic [COORD_W-1:0] x_end, y_end;
  logic               rev_start, last_px;

  assign x_end = width_i - COORD_W'(1);
  assign y_end = height_i - COORD_W'(1);

  // destination later in raster order than source: walk backwards
  assign rev_start = (new_dst_y_i > src_y_i) ||
                     ((new_dst_y_i == src_y_i) && (dst_x_i > src_x_i));

  assign last_px = rev_q ? ((ox_q == '0) && (oy_q == '0))
                         : ((ox_q == x_end) && (oy_q == y_end));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q  <= ST_IDLE;
      rev_q <= 1'b0;
      ox_q  <= '0;
      oy_q  <= '0;
    end else begin
      unique case (st_q)
        ST_IDLE: if (start_i) begin
          st_q  <= ST_RD;
          rev_q <= rev_start;
          ox_q  <= rev_start ? x_end : '0;
          oy_q  <= rev_start ? y_end : '0;
        end
        ST_RD: st_q <= ST_WR;
        ST_WR: begin
          if (last_px) begin
            st_q <= ST_IDLE;
          end else begin
            st_q <= ST_RD;
            if (!rev_q) begin
              if (ox_q == x_end) begin
                ox_q <= '0;
                oy_q <= oy_q + COORD_W'(1);
              end else begin
                ox_q <= ox_q + COORD_W'(1);
              end
            end else begin
              if (ox_q == '0) begin
                ox_q <= x_end;
                oy_q <= oy_q - COORD_W'(1);
              end else begin
                ox_q <= ox_q - COORD_W'(1);
              end
            end
          end
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign rd_o    = (st_q == ST_RD);
  assign wr_o    = (st_q == ST_WR);
  assign busy_o  = (st_q != ST_IDLE);
  assign off_x_o = ox_q;
  assign off_y_o = oy_q;

  // R5
  rd_then_wr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_o |=> wr_o)
    else $error("read not followed by write");

  // R5
  wr_then_rd_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_o && !last_px) |=> rd_o)
    else $error("pixel gap after write");

  // R3
  off_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> (off_x_o < width_i) && (off_y_o < height_i))
    else $error("scan offset outside rectangle");

  // R8
  dir_stable_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_o |=> $stable(rev_q))
    else $error("scan direction changed mid copy");
endmodule

// File: rtl/blit_addr.sv
module blit_addr #(
  parameter int unsigned FB_W    = 1920,
  parameter int unsigned COORD_W = 11,
  parameter int unsigned ADDR_W  = 21
) (
  input  logic [COORD_W-1:0] base_x_i,
  input  logic [COORD_W-1:0] base_y_i,
  input  logic [COORD_W-1:0] off_x_i,
  input  logic [COORD_W-1:0] off_y_i,
  output logic [ADDR_W-1:0]  addr_o
);
  logic [ADDR_W-1:0] row, col;

  assign row    = ADDR_W'(base_y_i) + ADDR_W'(off_y_i);
  assign col    = ADDR_W'(base_x_i) + ADDR_W'(off_x_i);
  assign addr_o = row * ADDR_W'(FB_W) + col;
endmodule

// File: rtl/rect_blit.sv
module rect_blit
  import blit_pkg::*;
#(
  parameter int unsigned FB_W  = 1920,
  parameter int unsigned FB_H  = 1080,
  parameter int unsigned PIX_W = 16,
  parameter int unsigned REG_W = 16,
  parameter int unsigned SEL_W = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              host_sel_i,
  input  logic              host_we_i,
  input  logic [SEL_W-1:0]  host_addr_i,
  input  logic [REG_W-1:0]  host_wdata_i,
  output logic [REG_W-1:0]  host_rdata_o,
  output logic              host_ready_o,
  output logic              mem_req_o,
  output logic              mem_we_o,
  output logic [$clog2(FB_W*FB_H)-1:0] mem_addr_o,
  output logic [PIX_W-1:0]  mem_wdata_o,
  input  logic [PIX_W-1:0]  mem_rdata_i
);
  localparam int unsigned MAX_DIM = (FB_W > FB_H) ? FB_W : FB_H;
  localparam int unsigned COORD_W = $clog2(MAX_DIM + 1);
  localparam int unsigned ADDR_W  = $clog2(FB_W * FB_H);

  logic               reg_we, launch, busy, rd_ph, wr_ph;
  logic [COORD_W-1:0] width, height, src_x, src_y, dst_x, new_dst_y;
  logic [COORD_W-1:0] off_x, off_y;
  logic [COORD_W-1:0] base_x [2];
  logic [COORD_W-1:0] base_y [2];
  logic [ADDR_W-1:0]  side_addr [2];
  logic [COORD_W-1:0] dst_y_rb;

  // host writes are dropped while a copy runs
  assign reg_we = host_sel_i && host_we_i && !busy;

  blit_regs #(
    .COORD_W(COORD_W), .DATA_W(REG_W), .SEL_W(SEL_W)
  ) u_regs (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .wr_en_i     (reg_we),
    .sel_i       (host_addr_i),
    .wdata_i     (host_wdata_i),
    .rdata_o     (host_rdata_o),
    .width_o     (width),
    .height_o    (height),
    .src_x_o     (src_x),
    .src_y_o     (src_y),
    .dst_x_o     (dst_x),
    .new_dst_y_o (new_dst_y),
    .launch_o    (launch)
  );

  blit_scan #(.COORD_W(COORD_W)) u_scan (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .start_i     (launch),
    .width_i     (width),
    .height_i    (height),
    .src_x_i     (src_x),
    .src_y_i     (src_y),
    .dst_x_i     (dst_x),
    .new_dst_y_i (new_dst_y),
    .busy_o      (busy),
    .rd_o        (rd_ph),
    .wr_o        (wr_ph),
    .off_x_o     (off_x),
    .off_y_o     (off_y)
  );

  // destination row register, held stable while busy
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) dst_y_rb <= '0;
    else if (reg_we && host_addr_i == SEL_W'(OFS_DST_Y)) dst_y_rb <= new_dst_y;
  end

  assign base_x[0] = src_x;
  assign base_y[0] = src_y;
  assign base_x[1] = dst_x;
  assign base_y[1] = dst_y_rb;

  // index 0 source side, index 1 destination side
  for (genvar s = 0; s < 2; s++) begin : g_side
    blit_addr #(.FB_W(FB_W), .COORD_W(COORD_W), .ADDR_W(ADDR_W)) u_addr (
      .base_x_i (base_x[s]),
      .base_y_i (base_y[s]),
      .off_x_i  (off_x),
      .off_y_i  (off_y),
      .addr_o   (side_addr[s])
    );
  end

  assign host_ready_o = !busy;
  assign mem_req_o    = rd_ph || wr_ph;
  assign mem_we_o     = wr_ph;
  assign mem_addr_o   = wr_ph ? side_addr[1] : side_addr[0];
  assign mem_wdata_o  = mem_rdata_i;

  // R3
  idle_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    host_ready_o |-> !mem_req_o)
    else $error("memory access while host not stalled");

  // R4
  zero_launch_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (host_sel_i && host_we_i && host_ready_o && host_addr_i == SEL_W'(OFS_DST_Y) &&
     (width == '0 || height == '0)) |=> host_ready_o)
    else $error("empty rectangle stalled host");

  // R3
  launch_stall_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    launch |=> !host_ready_o && mem_req_o && !mem_we_o)
    else $error("launch did not start with a read");

  // R5
  we_needs_req_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_we_o |-> mem_req_o)
    else $error("write enable without request");
endmodule

// File: tb/rect_blit_bench.sv
`timescale 1ns/1ps
module rect_blit_bench;
  localparam int FBW = 1920;
  localparam int FBH = 1080;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        host_sel = 1'b0, host_we = 1'b0;
  logic [2:0]  host_addr = '0;
  logic [15:0] host_wdata = '0;
  logic [15:0] host_rdata;
  logic        host_ready, mem_req, mem_we;
  logic [20:0] mem_addr;
  logic [15:0] mem_wdata;
  logic [15:0] mem_rdata = '0;

  always #2 clk = ~clk;

  rect_blit u_rect_blit (
    .clk_i(clk), .rst_ni(rst_n),
    .host_sel_i(host_sel), .host_we_i(host_we), .host_addr_i(host_addr),
    .host_wdata_i(host_wdata), .host_rdata_o(host_rdata), .host_ready_o(host_ready),
    .mem_req_o(mem_req), .mem_we_o(mem_we), .mem_addr_o(mem_addr),
    .mem_wdata_o(mem_wdata), .mem_rdata_i(mem_rdata)
  );

  logic [15:0] mem  [int];
  logic [15:0] refm [int];
  int n_chk = 0, n_fail = 0;
  bit finished = 0;

  int busy_cyc = 0, n_rd = 0, n_wr = 0, first_wr = -1, proto_err = 0;
  bit prev_rd = 0;

  function automatic logic [15:0] pat(int a);
    return 16'((a * 37) ^ (a >>> 4) ^ 16'h5a3c);
  endfunction
  function automatic logic [15:0] mget(int a);
    return mem.exists(a) ? mem[a] : pat(a);
  endfunction
  function automatic logic [15:0] rget(int a);
    return refm.exists(a) ? refm[a] : pat(a);
  endfunction

  // frame-buffer model with one clock of read latency
  always @(posedge clk) begin
    if (!host_ready) busy_cyc++;
    if (mem_req && host_ready) proto_err++;
    if (mem_req && mem_we) begin
      if (!prev_rd) proto_err++;
      if (n_wr == 0) first_wr = int'(mem_addr);
      mem[int'(mem_addr)] = mem_wdata;
      n_wr++;
    end else if (mem_req) begin
      mem_rdata <= mget(int'(mem_addr));
      n_rd++;
    end
    prev_rd = mem_req && !mem_we;
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic reg_wr(input int sel, input int data);
    @(negedge clk);
    host_sel = 1; host_we = 1; host_addr = 3'(sel); host_wdata = 16'(data);
    @(negedge clk);
    host_sel = 0; host_we = 0;
  endtask

  task automatic reg_rd(input int sel, output int data);
    @(negedge clk);
    host_addr = 3'(sel);
    #1 data = int'(host_rdata);
  endtask

  task automatic wait_ready();
    for (int g = 0; g < 2000 && !host_ready; g++) @(negedge clk);
  endtask

  task automatic run_copy(input int w, input int h, input int sx, input int sy,
                          input int dx, input int dy, input bit poke);
    logic [15:0] tmp [64];
    bit rev;
    int exp_first, bad, rb;
    for (int j = 0; j < h; j++)
      for (int i = 0; i < w; i++) tmp[j*w+i] = rget((sy+j)*FBW + sx + i);
    for (int j = 0; j < h; j++)
      for (int i = 0; i < w; i++) refm[(dy+j)*FBW + dx + i] = tmp[j*w+i];
    reg_wr(0, w); reg_wr(1, h); reg_wr(2, sx); reg_wr(3, sy); reg_wr(4, dx);
    @(negedge clk);
    busy_cyc = 0; n_rd = 0; n_wr = 0; first_wr = -1; proto_err = 0;
    reg_wr(5, dy);
    if (w == 0 || h == 0) begin
      repeat (3) @(negedge clk);
      chk(host_ready == 1 && n_rd == 0 && n_wr == 0, "R4", "empty copy accesses",
          n_rd + n_wr, 0);
      return;
    end
    chk(host_ready == 0, "R3", "ready after launch", int'(host_ready), 0);
    if (poke) begin
      host_sel = 1; host_we = 1; host_addr = 3'd0; host_wdata = 16'd3;
      @(negedge clk);
      host_sel = 0; host_we = 0;
    end
    wait_ready();
    chk(busy_cyc == 2*w*h, "R5", "stall cycles", busy_cyc, 2*w*h);
    chk(n_rd == w*h && n_wr == w*h && proto_err == 0, "R5", "read/write pairing",
        n_rd + n_wr + 1000*proto_err, 2*w*h);
    rev = (dy > sy) || (dy == sy && dx > sx);
    exp_first = rev ? (dy+h-1)*FBW + dx + w - 1 : dy*FBW + dx;
    chk(first_wr == exp_first, rev ? "R8" : "R7", "first write address",
        first_wr, exp_first);
    bad = 0;
    foreach (mem[k]) if (mem[k] !== rget(k)) bad++;
    foreach (refm[k]) if (refm[k] !== mget(k)) bad++;
    chk(bad == 0, "R6", "frame buffer mismatches (R8 overlap)", bad, 0);
    if (poke) begin
      reg_rd(0, rb);
      chk(rb == w, "R9", "width after write during copy", rb, w);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    int rb, w, h, sx, sy, dx, dy;
    int vals [6];
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1
    chk(host_ready == 1 && mem_req == 0, "R1", "idle outputs after reset",
        int'(host_ready) + 2*int'(mem_req), 1);
    for (int r = 0; r < 6; r++) begin
      reg_rd(r, rb);
      chk(rb == 0, "R1", "register reset value", rb, 0);
    end
    // R2: width 0 first so the row write does not launch
    vals[0] = 0;
    reg_wr(0, 0);
    for (int r = 1; r < 6; r++) begin
      vals[r] = int'($urandom_range(0, 16'hffff));
      reg_wr(r, vals[r]);
    end
    chk(host_ready == 1, "R4", "zero width launch ready", int'(host_ready), 1);
    vals[0] = int'($urandom_range(0, 16'hffff));
    reg_wr(0, vals[0]);
    for (int r = 0; r < 6; r++) begin
      reg_rd(r, rb);
      chk(rb == (vals[r] & 16'h07ff), "R2", "register readback", rb, vals[r] & 16'h07ff);
    end
    for (int r = 6; r < 8; r++) begin
      reg_wr(r, 16'hffff);
      reg_rd(r, rb);
      chk(rb == 0, "R2", "unused address readback", rb, 0);
    end
    // directed corners
    run_copy(0, 5, 10, 10, 40, 40, 0);             // R4 zero width
    run_copy(5, 0, 10, 10, 40, 40, 0);             // R4 zero height
    run_copy(4, 3, 100, 50, 200, 60, 0);           // R7 disjoint, dst below? no: R8
    run_copy(6, 4, 300, 20, 301, 20, 0);           // R8 same row shift right
    run_copy(6, 4, 300, 20, 299, 20, 0);           // R7 same row shift left
    run_copy(5, 5, 500, 500, 500, 501, 0);         // R8 one row down
    run_copy(5, 5, 500, 500, 500, 499, 0);         // R7 one row up
    run_copy(3, 3, 700, 700, 700, 700, 0);         // R7 identical
    run_copy(8, 8, FBW-8, FBH-8, 0, 0, 0);         // R6 bottom-right corner
    run_copy(8, 8, 0, 0, FBW-8, FBH-8, 0);         // R6 to far corner
    run_copy(8, 8, 40, 40, 900, 600, 1);           // R9 write during copy
    // random mix, half overlapping
    for (int n = 0; n < 30; n++) begin
      w  = 1 + int'($urandom_range(0, 7));
      h  = 1 + int'($urandom_range(0, 7));
      sx = int'($urandom_range(0, FBW - w));
      sy = int'($urandom_range(0, FBH - h));
      if (n % 2 == 0) begin
        dx = sx + int'($urandom_range(0, 6)) - 3;
        dy = sy + int'($urandom_range(0, 6)) - 3;
        if (dx < 0) dx = 0;
        if (dy < 0) dy = 0;
        if (dx > FBW - w) dx = FBW - w;
        if (dy > FBH - h) dy = FBH - h;
      end else begin
        dx = int'($urandom_range(0, FBW - w));
        dy = int'($urandom_range(0, FBH - h));
      end
      run_copy(w, h, sx, sy, dx, dy, 0);
    end
    finish_run();
  end
endmodule